// File: doc/BRIEF.md
# Byte-Oriented Serial Bus Target with Clock Hold

This block is the target end of a two-wire, open-drain serial bus (I2C). It takes the raw clock and data lines as seen at the pads, cleans them with a synchroniser and a small majority filter, and finds the bus conditions: START, repeated START and STOP. The first byte after any START carries a 7-bit address and a direction bit. The block compares that address with its own, which comes in on an input port. It acknowledges a match and stays silent on any other address.

Once addressed, the block moves whole bytes between the bus and a local byte port. Each direction of that port has its own valid/ready handshake. The local side need not be ready at once. After every byte, and before a byte is sent, the block holds the clock line low until the local side has taken the received byte or supplied the next one. The controller's clock therefore waits for the back end rather than overrunning it. The block never drives a line high: it only asserts pull-down enables, and the pads combine them with the pull-ups.

Top module: `i2c_target`

## Requirements
- R1: While reset is held, both pull-down enables (`scl_oe`, `sda_oe`) and both local strobes (`rx_valid`, `tx_ready`) are 0.
- R2: After a START, the first eight clock pulses shift in the address, most significant bit first, with the direction bit (0 = controller writes, 1 = controller reads) as the eighth bit. If the seven address bits equal `own_addr`, the target pulls SDA low through the ninth clock pulse.
- R3: On an address mismatch the target does not acknowledge. It keeps both enables at 0 and ignores further bytes (no ACK, no `rx_valid`) until the next START.
- R4: In write mode each data byte is assembled most significant bit first and shown on `rx_data` with `rx_valid` high. `rx_data` stays unchanged until `rx_ready` is seen, and every accepted byte is acknowledged.
- R5: In write mode the target holds SCL low from the falling edge after the eighth data bit until the byte is accepted (`rx_valid` and `rx_ready` both high). SCL is held only while the local side is being waited on.
- R6: In read mode the target holds SCL low with `tx_ready` high before each byte until `tx_valid` is seen. It then puts the `tx_data` byte on SDA most significant bit first, changing SDA only while SCL is low. `rx_valid` and `tx_ready` are never high together.
- R7: In read mode an ACK (SDA low) from the controller in the ninth clock requests another byte. A NACK (SDA high) makes the target release both lines and request no more bytes until the next START.
- R8: A repeated START, with no STOP in between, restarts address reception. The new address and direction are evaluated afresh.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle. Clock pulses that follow without a START are ignored.
- R10: A pulse of a single clock cycle on either line input does not count as a clock edge, a START or a STOP.
- R11: The address is taken from `own_addr` when the address byte ends. A new value applied between transactions takes effect for the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_data | output | 8 | Byte received from the controller |
| rx_valid | output | 1 | `rx_data` holds a byte waiting to be taken |
| rx_ready | input | 1 | Local side takes the byte on `rx_data` |
| tx_data | input | 8 | Byte for the controller to read |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Target is waiting for a byte to send |

## Verification
The hardest state to reach is the clock hold itself. The hold lasts only as long as the local side withholds its handshake, and the bus controller must notice it through the wired line rather than through its own timing. The bench models the local side as a responder with a programmable delay, and its controller waits for the combined clock line to actually go high. A long delay on one chosen byte in a write sweep, and on the first byte of a read, therefore shows up as a measurable wait in the controller. Single-cycle glitches are forced onto the combined lines in the middle of a high phase, which is the only point where a glitch could fake a START or an extra bit.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BIT,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX_LOAD,
        ST_TX_BIT,
        ST_TX_ACK,
        ST_PARK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                rd;
        logic                ctl_ack;
        logic                scl_oe;
        logic                sda_oe;
    } tgt_regs_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [TAPS-1:0]        hist;
        logic                   out;
    } filt_regs_t;

    filt_regs_t r_d, r_q;

    // Majority vote over the sample history; ties cannot occur for odd TAPS.
    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC_STAGES-2:0], line_i};
        r_d.hist = {r_q.hist[TAPS-2:0], r_q.sync[SYNC_STAGES-1]};
        if (2 * $countones(r_q.hist) > TAPS) begin
            r_d.out = 1'b1;
        end else begin
            r_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.out;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.scl      = scl_f;
        p_d.sda      = sda_f;
        evt.scl_rise = !p_q.scl && scl_f;
        evt.scl_fall = p_q.scl && !scl_f;
        evt.start    = p_q.scl && scl_f && p_q.sda && !sda_f;
        evt.stop     = p_q.scl && scl_f && !p_q.sda && sda_f;
        evt.sda      = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '1;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  bus_evt_t          evt,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.scl_oe = 1'b0;
                r_d.sda_oe = 1'b0;
            end
            ST_ADDR: begin
                if (evt.scl_rise) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], evt.sda};
                    r_d.cnt = r_q.cnt + 1'b1;
                end
                if (evt.scl_fall && r_q.cnt == CNT_FULL) begin
                    if (r_q.sh[BYTE_W-1 -: ADDR_W] == own_addr) begin
                        r_d.st     = ST_ADDR_ACK;
                        r_d.rd     = r_q.sh[0];
                        r_d.sda_oe = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            ST_ADDR_ACK: begin
                if (evt.scl_fall) begin
                    r_d.sda_oe = 1'b0;
                    r_d.cnt    = '0;
                    if (r_q.rd) begin
                        r_d.st     = ST_TX_LOAD;
                        r_d.scl_oe = 1'b1;
                    end else begin
                        r_d.st = ST_RX_BIT;
                    end
                end
            end
            ST_RX_BIT: begin
                if (evt.scl_rise) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], evt.sda};
                    r_d.cnt = r_q.cnt + 1'b1;
                end
                if (evt.scl_fall && r_q.cnt == CNT_FULL) begin
                    r_d.st     = ST_RX_HOLD;
                    r_d.scl_oe = 1'b1;
                end
            end
            ST_RX_HOLD: begin
                if (rx_ready) begin
                    r_d.st     = ST_RX_ACK;
                    r_d.sda_oe = 1'b1;
                    r_d.scl_oe = 1'b0;
                end
            end
            ST_RX_ACK: begin
                if (evt.scl_fall) begin
                    r_d.st     = ST_RX_BIT;
                    r_d.sda_oe = 1'b0;
                    r_d.cnt    = '0;
                end
            end
            ST_TX_LOAD: begin
                if (tx_valid) begin
                    r_d.st     = ST_TX_BIT;
                    r_d.sh     = tx_data;
                    r_d.sda_oe = !tx_data[BYTE_W-1];
                    r_d.scl_oe = 1'b0;
                    r_d.cnt    = '0;
                end
            end
            ST_TX_BIT: begin
                if (evt.scl_fall) begin
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.st     = ST_TX_ACK;
                        r_d.sda_oe = 1'b0;
                        r_d.cnt    = '0;
                    end else begin
                        r_d.sh     = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.sda_oe = !r_q.sh[BYTE_W-2];
                        r_d.cnt    = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_TX_ACK: begin
                if (evt.scl_rise) begin
                    r_d.ctl_ack = !evt.sda;
                end
                if (evt.scl_fall) begin
                    if (r_q.ctl_ack) begin
                        r_d.st     = ST_TX_LOAD;
                        r_d.scl_oe = 1'b1;
                    end else begin
                        r_d.st = ST_PARK;
                    end
                end
            end
            ST_PARK: begin
                r_d.scl_oe = 1'b0;
                r_d.sda_oe = 1'b0;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Bus conditions override whatever the byte engine was doing.
        if (evt.stop) begin
            r_d.st     = ST_IDLE;
            r_d.scl_oe = 1'b0;
            r_d.sda_oe = 1'b0;
        end
        if (evt.start) begin
            r_d.st     = ST_ADDR;
            r_d.cnt    = '0;
            r_d.scl_oe = 1'b0;
            r_d.sda_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe   = r_q.scl_oe;
    assign sda_oe   = r_q.sda_oe;
    assign rx_data  = r_q.sh;
    assign rx_valid = (r_q.st == ST_RX_HOLD);
    assign tx_ready = (r_q.st == ST_TX_LOAD);

endmodule

// File: rtl/i2c_target.sv
module i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] filt_lines;
    logic             scl_filt;
    logic             sda_filt;
    bus_evt_t         evt;

    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            i2c_line_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .TAPS       (FILT_TAPS)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .line_i(raw_lines[g]),
                .line_o(filt_lines[g])
            );
        end
    endgenerate

    assign scl_filt = filt_lines[0];
    assign sda_filt = filt_lines[1];

    i2c_bus_events u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(scl_filt),
        .sda_f(sda_filt),
        .evt  (evt)
    );

    i2c_target_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_addr(own_addr),
        .evt     (evt),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .rx_data (rx_data),
        .rx_valid(rx_valid),
        .rx_ready(rx_ready),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready)
    );

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk
    import i2c_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_filt,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_ready
);

    AST_RX_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> scl_oe); // R5

    AST_SCL_HOLD_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (rx_valid || tx_ready)); // R5

    AST_TX_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> scl_oe); // R6

    AST_ONE_SIDE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_ready)); // R6

    AST_RX_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R4

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_filt)); // R6

endmodule

bind i2c_target i2c_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_filt(scl_filt),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .rx_data (rx_data),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .tx_ready(tx_ready)
);

// File: tb/i2c_target_test.sv
`timescale 1ns/1ps
module i2c_target_test;

    localparam int Q = 6;
    localparam logic [6:0] ADDR_A = 7'h2A;
    localparam logic [6:0] ADDR_B = 7'h51;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] own_addr = ADDR_A;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_gl = 1'b0, sda_gl = 1'b0;
    logic       scl_bus, sda_bus;
    logic       scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;

    int n_tests = 0;
    int n_fail  = 0;
    int rx_delay = 0;
    int tx_delay = 0;
    int rx_cnt = 0;
    int tx_cnt = 0;
    int last_wait = 0;
    int first_wait = 0;
    logic [7:0] rx_log [512];

    always #4 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe & ~scl_gl;
    assign sda_bus = sda_m & ~sda_oe & ~sda_gl;

    i2c_target uut (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    function automatic logic [7:0] tx_byte(int k);
        return 8'(k * 53 + 17);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Local receive side with programmable latency.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                repeat (rx_delay) @(negedge clk);
                if (rx_cnt < 512) rx_log[rx_cnt] = rx_data;
                rx_cnt++;
                rx_ready = 1'b1;
                @(negedge clk);
                rx_ready = 1'b0;
            end
        end
    end

    // Local transmit side with programmable latency.
    initial begin
        forever begin
            @(negedge clk);
            if (tx_ready) begin
                repeat (tx_delay) @(negedge clk);
                tx_data  = tx_byte(tx_cnt);
                tx_valid = 1'b1;
                @(negedge clk);
                tx_valid = 1'b0;
                tx_cnt++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        last_wait = 0;
        @(negedge clk);
        while (!scl_bus) begin
            @(negedge clk);
            last_wait++;
        end
    endtask

    task automatic send_bit(input logic b, input bit gl, output logic rb);
        tick(Q);
        sda_m = b;
        tick(Q);
        scl_high();
        if (gl) begin
            scl_gl = 1'b1; tick(1); scl_gl = 1'b0; tick(1);
            sda_gl = 1'b1; tick(1); sda_gl = 1'b0; tick(Q - 3);
        end else begin
            tick(Q);
        end
        rb = sda_bus;
        tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic start_cond();
        sda_m = 1'b1;
        tick(2 * Q);
        scl_high();
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic stop_cond();
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_high();
        tick(Q);
        sda_m = 1'b1;
        tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit gl, output bit ack);
        logic rb;
        for (int i = 7; i >= 0; i--) send_bit(v[i], gl, rb);
        send_bit(1'b1, 1'b0, rb);
        ack = !rb;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic rb;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, 1'b0, rb);
            if (i == 7) first_wait = last_wait;
            v[i] = rb;
        end
        send_bit(!give_ack, 1'b0, rb);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int base;

        // R1: reset state
        tick(10);
        check(scl_oe == 1'b0, "R1 scl_oe", int'(scl_oe), 0);
        check(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        check(tx_ready == 1'b0, "R1 tx_ready", int'(tx_ready), 0);
        rst_n = 1'b1;
        tick(10);

        // R2 / R3: sweep every address with write direction
        for (int a = 0; a < 128; a++) begin
            start_cond();
            send_byte({7'(a), 1'b0}, 1'b0, ack);
            stop_cond();
            if (7'(a) == ADDR_A) check(ack == 1'b1, "R2 own address ack", int'(ack), 1);
            else                 check(ack == 1'b0, "R3 foreign address nack", int'(ack), 0);
        end
        check(rx_cnt == 0, "R2 no data after address only", rx_cnt, 0);

        // R3: bytes after a mismatch are ignored
        start_cond();
        send_byte({7'h15, 1'b0}, 1'b0, ack);
        send_byte(8'hC3, 1'b0, ack);
        check(ack == 1'b0, "R3 data after mismatch nacked", int'(ack), 0);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R3 lines released", int'({scl_oe, sda_oe}), 0);
        stop_cond();
        check(rx_cnt == 0, "R3 no byte delivered", rx_cnt, 0);

        // R4 / R5: write every byte value, one with a slow local side
        start_cond();
        send_byte({ADDR_A, 1'b0}, 1'b0, ack);
        check(ack == 1'b1, "R4 write address ack", int'(ack), 1);
        for (int d = 0; d < 256; d++) begin
            rx_delay = (d == 100) ? 50 : 0;
            send_byte(8'(d), 1'b0, ack);
            check(ack == 1'b1, "R4 data ack", int'(ack), 1);
            if (d == 100) check(last_wait >= 30, "R5 scl held for slow sink", last_wait, 30);
        end
        rx_delay = 0;
        stop_cond();
        check(rx_cnt == 256, "R4 byte count", rx_cnt, 256);
        for (int d = 0; d < 256; d++)
            check(rx_log[d] == 8'(d), "R4 byte value msb first", int'(rx_log[d]), d);

        // R6 / R7: read sixteen bytes, slow first byte, nack on last
        tx_delay = 50;
        start_cond();
        send_byte({ADDR_A, 1'b1}, 1'b0, ack);
        check(ack == 1'b1, "R6 read address ack", int'(ack), 1);
        for (int k = 0; k < 16; k++) begin
            recv_byte(k != 15, v);
            if (k == 0) begin
                check(first_wait >= 30, "R6 scl held for slow source", first_wait, 30);
                tx_delay = 0;
            end
            check(v == tx_byte(k), "R6 read byte msb first", int'(v), int'(tx_byte(k)));
        end
        tick(4 * Q);
        check(tx_ready == 1'b0, "R7 no request after nack", int'(tx_ready), 0);
        check(sda_oe == 1'b0 && scl_oe == 1'b0, "R7 lines released after nack", int'({scl_oe, sda_oe}), 0);
        check(tx_cnt == 16, "R7 bytes requested", tx_cnt, 16);
        stop_cond();

        // R8: repeated START re-evaluates the address
        base = rx_cnt;
        start_cond();
        send_byte({ADDR_A, 1'b0}, 1'b0, ack);
        send_byte(8'h5A, 1'b0, ack);
        check(ack == 1'b1 && rx_log[base] == 8'h5A, "R8 byte before restart", int'(rx_log[base]), 'h5A);
        start_cond();
        send_byte({7'h2B, 1'b0}, 1'b0, ack);
        check(ack == 1'b0, "R8 foreign address after restart", int'(ack), 0);
        start_cond();
        send_byte({ADDR_A, 1'b1}, 1'b0, ack);
        check(ack == 1'b1, "R8 own read address after restart", int'(ack), 1);
        recv_byte(1'b0, v);
        check(v == tx_byte(16), "R8 read after restart", int'(v), int'(tx_byte(16)));
        stop_cond();

        // R9: clocks after STOP without START are ignored
        base = rx_cnt;
        start_cond();
        send_byte({ADDR_A, 1'b0}, 1'b0, ack);
        stop_cond();
        scl_m = 1'b0;
        send_byte(8'hFF, 1'b0, ack);
        check(ack == 1'b0, "R9 no ack after stop", int'(ack), 0);
        tick(4 * Q);
        check(rx_cnt == base, "R9 no byte after stop", rx_cnt, base);
        stop_cond();

        // R10: single-cycle glitches on both lines during high phases
        base = rx_cnt;
        start_cond();
        send_byte({ADDR_A, 1'b0}, 1'b1, ack);
        check(ack == 1'b1, "R10 address with glitches", int'(ack), 1);
        send_byte(8'hB6, 1'b1, ack);
        check(ack == 1'b1, "R10 data ack with glitches", int'(ack), 1);
        stop_cond();
        check(rx_cnt == base + 1 && rx_log[base] == 8'hB6, "R10 data with glitches", int'(rx_log[base]), 'hB6);

        // R11: new own address between transactions
        own_addr = ADDR_B;
        start_cond();
        send_byte({ADDR_B, 1'b0}, 1'b0, ack);
        stop_cond();
        check(ack == 1'b1, "R11 new address acked", int'(ack), 1);
        start_cond();
        send_byte({ADDR_A, 1'b0}, 1'b0, ack);
        stop_cond();
        check(ack == 1'b0, "R11 old address ignored", int'(ack), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule